// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This block sits between a load requester and a memory port that can only return whole, naturally aligned 32-bit words. It accepts byte, halfword and word loads at any byte address. When all requested bytes fall inside one aligned word, it issues a single word read, moves the wanted bytes down to the low end of the result and widens them by zero or sign extension. When the bytes run across a word boundary, it reads the lower word and then the next one. It shifts each word so that its bytes land in the right lanes, ORs the two parts and widens the merged value.

A strict-mode input turns the split path off. A load that is not naturally aligned for its size then finishes at once with a fault flag, and the memory sees no read. The memory port may answer each read after any number of cycles. The unit holds one load at a time and lowers its ready output while the load is in flight.

Top module: `ld_merge_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid` and `mem_rd_en` are low and `req_ready` is high.
- R2: The first read of a load uses word address `req_addr[31:2]`. The second read, when there is one, uses that word address plus one, and it wraps from all ones to zero.
- R3: The size code is 0 for byte (1 byte), 1 for halfword (2 bytes), 2 for word (4 bytes), and code 3 acts as a word. Let the byte count be n. A load reads two words when `req_addr[1:0] + n > 4` and one word otherwise. `rsp_reads` reports that count on every non-faulting response.
- R4: Byte order is little-endian. Result byte i (bits 8i+7..8i) is the memory byte at address `req_addr + i`, and word byte lane k holds the byte at word address ×4 + k.
- R5: For byte and halfword loads, the bits above the loaded data copy the top loaded bit when `req_signed` is 1 and are zero when it is 0.
- R6: `rsp_valid` is a one-cycle pulse. It rises in the cycle right after the cycle in which the last needed `mem_rvalid` was high.
- R7: With `strict_mode` high, a halfword at an odd address or a word at an address not divisible by 4 issues no read. It answers in the cycle after acceptance with `rsp_fault` = 1, `rsp_data` = 0 and `rsp_reads` = 0. Naturally aligned loads in strict mode complete normally with `rsp_fault` = 0.
- R8: A load is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low from the cycle after acceptance until the response pulse, for every non-faulting load.
- R9: Every `mem_rd_en` assertion lasts exactly one cycle. The unit waits for `mem_rvalid` however many cycles it takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | 32 | Byte address of the load |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 word |
| req_signed | input | 1 | 1 selects sign extension, 0 zero extension |
| strict_mode | input | 1 | 1 faults misaligned loads instead of splitting them |
| req_ready | output | 1 | Unit idle and able to accept a load |
| mem_rd_en | output | 1 | One-cycle word read request |
| mem_word_addr | output | 30 | Aligned word address of the read |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Returned aligned word |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Assembled and extended load result |
| rsp_fault | output | 1 | Misalignment fault (meaningful with rsp_valid) |
| rsp_reads | output | 2 | Number of word reads used by this load |

## Verification
Directed loads cover each of these cases:
- a halfword inside one word, which tells the one-read path from the split path;
- a word at offset 1 and halfwords or words at offset 3, which check that both shift amounts are right and that the merge is an OR rather than a replacement;
- a word at the top of the address space, which shows whether the second word address wraps;
- strict-mode loads on both sides of the alignment rule, which separate a fault from a normal completion.

Seeded random loads then mix all sizes, offsets, signedness, strict mode and memory latencies of one to three cycles. This catches an extension that picks the wrong top bit or a response that is timed to the wrong read.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int BYTES = DW / 8;
    localparam int OFFW = $clog2(BYTES);
    localparam int WAW  = AW - OFFW;
    localparam int SHW  = OFFW + 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } ld_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ0,
        ST_WAIT0,
        ST_REQ1,
        ST_WAIT1
    } ld_state_e;

    typedef struct packed {
        ld_size_e          size;
        logic              sgn;
        logic [OFFW-1:0]   off;
        logic              split;
        logic [WAW-1:0]    wa_lo;
        logic [WAW-1:0]    wa_hi;
    } ld_ctx_t;

    function automatic logic [OFFW:0] size_bytes(ld_size_e s);
        case (s)
            SZ_BYTE: return (OFFW+1)'(1);
            SZ_HALF: return (OFFW+1)'(2);
            default: return (OFFW+1)'(BYTES);
        endcase
    endfunction

    function automatic logic [DW-1:0] extend_ld(logic [DW-1:0] d, ld_size_e s, logic sgn);
        case (s)
            SZ_BYTE: return {{(DW-8){sgn & d[7]}}, d[7:0]};
            SZ_HALF: return {{(DW-16){sgn & d[15]}}, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/ldm_addr_decode.sv
module ldm_addr_decode
    import ldm_pkg::*;
(
    input  logic [AW-1:0]  addr,
    input  ld_size_e       size,
    output logic [WAW-1:0] wa_first,
    output logic [WAW-1:0] wa_second,
    output logic [OFFW-1:0] off,
    output logic           straddle,
    output logic           misaligned
);

    logic [OFFW+1:0] span;

    always_comb begin
        wa_first  = addr[AW-1:OFFW];
        wa_second = wa_first + 1'b1;
        off       = addr[OFFW-1:0];
        span      = {2'b00, off} + {1'b0, size_bytes(size)};
        straddle  = span > (OFFW+2)'(BYTES);
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            default: misaligned = (off != '0);
        endcase
    end

endmodule

// File: rtl/ldm_merge.sv
module ldm_merge
    import ldm_pkg::*;
(
    input  logic [OFFW-1:0] off,
    input  logic [DW-1:0]   word,
    input  logic [DW-1:0]   lo_prev,
    output logic [DW-1:0]   lo_part,
    output logic [DW-1:0]   merged
);

    logic [SHW-1:0] sh_lo;
    logic [SHW-1:0] sh_hi;

    always_comb begin
        sh_lo   = {1'b0, off, 3'b000};
        sh_hi   = SHW'(DW) - sh_lo;
        lo_part = word >> sh_lo;
        merged  = lo_prev | (word << sh_hi);
    end

endmodule

// File: rtl/ld_merge_unit.sv
module ld_merge_unit
    import ldm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [1:0]      req_size,
    input  logic            req_signed,
    input  logic            strict_mode,
    output logic            req_ready,
    output logic            mem_rd_en,
    output logic [WAW-1:0]  mem_word_addr,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic            rsp_fault,
    output logic [1:0]      rsp_reads
);

    ld_size_e        in_size;
    logic [WAW-1:0]  dec_wa0, dec_wa1;
    logic [OFFW-1:0] dec_off;
    logic            dec_split, dec_misal;

    ld_state_e       state;
    ld_ctx_t         ctx;
    logic [DW-1:0]   lo_q;
    logic [DW-1:0]   lo_part, merged;

    logic            rsp_valid_q, rsp_fault_q;
    logic [DW-1:0]   rsp_data_q;
    logic [1:0]      rsp_reads_q;

    assign in_size = ld_size_e'(req_size);

    ldm_addr_decode u_decode (
        .addr       (req_addr),
        .size       (in_size),
        .wa_first   (dec_wa0),
        .wa_second  (dec_wa1),
        .off        (dec_off),
        .straddle   (dec_split),
        .misaligned (dec_misal)
    );

    ldm_merge u_merge (
        .off     (ctx.off),
        .word    (mem_rdata),
        .lo_prev (lo_q),
        .lo_part (lo_part),
        .merged  (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ctx         <= '0;
            lo_q        <= '0;
            rsp_valid_q <= 1'b0;
            rsp_fault_q <= 1'b0;
            rsp_data_q  <= '0;
            rsp_reads_q <= 2'd0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (strict_mode && dec_misal) begin
                            rsp_valid_q <= 1'b1;
                            rsp_fault_q <= 1'b1;
                            rsp_data_q  <= '0;
                            rsp_reads_q <= 2'd0;
                        end else begin
                            ctx.size  <= in_size;
                            ctx.sgn   <= req_signed;
                            ctx.off   <= dec_off;
                            ctx.split <= dec_split;
                            ctx.wa_lo <= dec_wa0;
                            ctx.wa_hi <= dec_wa1;
                            state     <= ST_REQ0;
                        end
                    end
                end
                ST_REQ0: state <= ST_WAIT0;
                ST_WAIT0: begin
                    if (mem_rvalid) begin
                        if (ctx.split) begin
                            lo_q  <= lo_part;
                            state <= ST_REQ1;
                        end else begin
                            rsp_valid_q <= 1'b1;
                            rsp_fault_q <= 1'b0;
                            rsp_data_q  <= extend_ld(lo_part, ctx.size, ctx.sgn);
                            rsp_reads_q <= 2'd1;
                            state       <= ST_IDLE;
                        end
                    end
                end
                ST_REQ1: state <= ST_WAIT1;
                ST_WAIT1: begin
                    if (mem_rvalid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_fault_q <= 1'b0;
                        rsp_data_q  <= extend_ld(merged, ctx.size, ctx.sgn);
                        rsp_reads_q <= 2'd2;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_rd_en     = (state == ST_REQ0) || (state == ST_REQ1);
        mem_word_addr = (state == ST_REQ1) ? ctx.wa_hi : ctx.wa_lo;
        rsp_valid     = rsp_valid_q;
        rsp_data      = rsp_data_q;
        rsp_fault     = rsp_fault_q;
        rsp_reads     = rsp_reads_q;
    end

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en); // R9

    AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> $past(mem_rvalid)); // R6

    AST_FAULT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> ($past(req_valid && req_ready && strict_mode) && rsp_reads == 2'd0)); // R7

    AST_READ_COUNT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_reads == 2'd1 || rsp_reads == 2'd2)); // R3

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready || rsp_valid)); // R8

endmodule

// File: tb/test_ld_merge_unit.sv
module test_ld_merge_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_signed;
    logic        strict_mode;
    logic        req_ready;
    logic        mem_rd_en;
    logic [29:0] mem_word_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_fault;
    logic [1:0]  rsp_reads;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    ld_merge_unit i_ld_merge_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_signed(req_signed), .strict_mode(strict_mode),
        .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_word_addr(mem_word_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_fault(rsp_fault), .rsp_reads(rsp_reads)
    );

    function automatic logic [31:0] mem_word(logic [29:0] wa);
        logic [31:0] x;
        x = {2'b01, wa} * 32'h9E37_79B1;
        return x ^ {x[15:0], x[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] exp_data(logic [31:0] a, int nb, logic sg);
        logic [31:0] r = '0;
        for (int i = 0; i < nb; i++) begin
            logic [31:0] ba = a + 32'(i);
            logic [31:0] w  = mem_word(ba[31:2]) >> (8 * ba[1:0]);
            r = r | ({24'b0, w[7:0]} << (8 * i));
        end
        if (nb < 4 && sg && r[8*nb-1])
            r = r | (32'hFFFF_FFFF << (8 * nb));
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model with 1..3 cycle latency
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [29:0] pa = '0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(posedge clk);
            mem_rvalid <= 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem_word(pa);
                    pend = 0;
                end else cnt--;
            end
            if (mem_rd_en) begin
                pend = 1;
                cnt  = $urandom_range(0, 2);
                pa   = mem_word_addr;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 150000) begin
                n_fails++;
                $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input logic sg, input logic st);
        int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        int off = int'(a[1:0]);
        bit split = (off + nb) > 4;
        bit mis = (nb == 2 && a[0]) || (nb == 4 && off != 0);
        bit flt = st && mis;
        int exp_rd = flt ? 0 : (split ? 2 : 1);
        logic [31:0] exp_d = flt ? 32'h0 : exp_data(a, nb, sg);
        logic [29:0] ra0 = '0, ra1 = '0;
        int k = 0, nrd = 0, last_rv = -1, rsp_at = -1;
        logic [31:0] got_d = '0;
        logic got_f = 1'b0;
        logic [1:0] got_r = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_signed = sg; strict_mode = st;
        while (rsp_at < 0 && k < 60) begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                req_valid = 1'b0;
                if (!flt) check(!req_ready, "R8 busy", {31'b0, req_ready}, 32'h0);
            end
            if (mem_rd_en) begin
                if (nrd == 0) ra0 = mem_word_addr; else ra1 = mem_word_addr;
                nrd++;
            end
            if (mem_rvalid) last_rv = k;
            if (rsp_valid) begin
                rsp_at = k; got_d = rsp_data; got_f = rsp_fault; got_r = rsp_reads;
            end
        end
        check(rsp_at > 0, "R9 response arrives", 32'(rsp_at), 32'h1);
        check(nrd == exp_rd, "R3 read count on bus", 32'(nrd), 32'(exp_rd));
        check(got_f == flt, "R7 fault flag", {31'b0, got_f}, {31'b0, flt});
        if (flt) begin
            check(rsp_at == 1, "R7 fault timing", 32'(rsp_at), 32'h1);
            check(got_r == 2'd0, "R7 fault reads", {30'b0, got_r}, 32'h0);
        end else begin
            check(got_r == 2'(exp_rd), "R3 rsp_reads", {30'b0, got_r}, 32'(exp_rd));
            check(ra0 == a[31:2], "R2 first word address", {2'b0, ra0}, {2'b0, a[31:2]});
            if (split) check(ra1 == a[31:2] + 30'd1, "R2 second word address", {2'b0, ra1}, {2'b0, a[31:2] + 30'd1});
            check(rsp_at == last_rv + 1, "R6 response one cycle after data", 32'(rsp_at), 32'(last_rv + 1));
        end
        if (nb < 4) check(got_d == exp_d, "R5 extended data", got_d, exp_d);
        else        check(got_d == exp_d, "R4 little-endian data", got_d, exp_d);
        @(negedge clk);
        check(!rsp_valid, "R6 single-cycle pulse", {31'b0, rsp_valid}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_signed = 1'b0; strict_mode = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!rsp_valid && !mem_rd_en && req_ready, "R1 during reset", {29'b0, rsp_valid, mem_rd_en, req_ready}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !mem_rd_en && req_ready, "R1 after reset", {29'b0, rsp_valid, mem_rd_en, req_ready}, 32'h1);

        do_load(32'h0000_0005, 2'd1, 1'b0, 1'b0); // R3 one read inside a word
        do_load(32'h0000_0001, 2'd2, 1'b0, 1'b0); // R4 split word at offset 1
        do_load(32'h0000_1003, 2'd1, 1'b1, 1'b0); // R5 split halfword signed
        do_load(32'h0000_1003, 2'd1, 1'b0, 1'b0); // R5 split halfword unsigned
        do_load(32'h0000_2003, 2'd2, 1'b0, 1'b0); // R4 split word at offset 3
        do_load(32'h0000_2002, 2'd2, 1'b0, 1'b0); // R4 split word at offset 2
        do_load(32'hFFFF_FFFD, 2'd2, 1'b0, 1'b0); // R2 address wrap
        do_load(32'h0000_0007, 2'd0, 1'b1, 1'b0); // R5 byte signed
        do_load(32'h0000_3001, 2'd3, 1'b0, 1'b0); // R3 reserved code acts as word
        do_load(32'h0000_0002, 2'd2, 1'b0, 1'b1); // R7 strict word fault
        do_load(32'h0000_0001, 2'd1, 1'b1, 1'b1); // R7 strict halfword fault
        do_load(32'h0000_0002, 2'd1, 1'b1, 1'b1); // R7 strict aligned completes
        do_load(32'h0000_0003, 2'd0, 1'b0, 1'b1); // R7 strict byte completes

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = $urandom;
            logic [1:0]  s = 2'($urandom_range(0, 3));
            do_load(a, s, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule